// File: doc/BRIEF.md
# Stack-Capable Multi-Cycle Datapath

This block is the 32-bit datapath of a processor that runs each instruction in five phases: fetch, decode, execute, memory and writeback. It holds the program counter, the instruction register, a stack pointer, a 32-entry by 32-bit register file with two registered read ports, and an ALU. It also holds the chains of two-way multiplexers that pick the ALU operands, the register write address and data, the memory address, the memory write data and the next program counter. An external control unit steers every register load and every multiplexer through one flat 29-bit control word. An external word-addressed memory receives the address and write data and returns read data.

Push and pop need no dedicated adder. The operand chains can route the stack pointer into the first ALU operand and the constant 1 into the second, so the ALU itself decrements or increments the pointer. Writeback can target rd, rt, r31 or r0. It can write the ALU result, memory data, an upper immediate or the incremented program counter.

Top module: `stack_dpath`

## Requirements
- R1: An active-low reset clears the register file, the instruction register and both read holding registers. It sets the program counter to 0x00001000 and the stack pointer to 0x03FFFFFF.
- R2: When control bit 4 is high, the instruction register captures mem_rdata at the clock edge. When it is low, the register holds. The instruction register drives `instr`, with opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], immediate [15:0] and jump target [25:0].
- R3: Control bits 28:23 select the ALU function: 1 add, 2 subtract, 3 multiply (low 32 bits), 4 logical right shift of operand A by operand B[4:0], 5 left shift, 6 and, 7 or, 8 nor, 9 signed set-less-than (result 1 or 0). Every other code gives 0.
- R4: `zero` is high exactly when the ALU result is 0.
- R5: Operand B is built in four steps. Bit 13 picks the constant 1 (0) or the zero-extended shamt (1). Bit 14 picks the zero-extended immediate (0) or the sign-extended immediate (1). Bit 15 picks the bit-14 result (0) or the bit-13 result (1). Bit 16 picks the bit-15 result (0) or read holding register 2 (1).
- R6: Operand A is read holding register 1 when bit 12 is 0 and the stack pointer when bit 12 is 1. The read-port-1 address is rs, or r0 when bit 7 is 1.
- R7: When bit 6 is high, the register file writes at the clock edge. The write address follows three steps. Bit 8 picks rd (0) or rt (1). Bit 9 picks r0 (0) or r31 (1). Bit 10 picks the bit-9 result (0) or the bit-8 result (1).
- R8: Write data follows three steps. Bit 17 picks the ALU result (0) or mem_rdata (1). Bit 18 picks the bit-17 result (0) or the immediate placed in bits 31:16 with zero low bits (1). Bit 19 picks PC+1 (0) or the bit-18 result (1).
- R9: When bit 0 is high, the program counter loads the next-PC value; otherwise it holds. Bit 1 picks read holding register 1 (0) or PC+1 (1). Bit 2 picks the bit-1 result (0) or PC+1 plus the sign-extended immediate (1). Bit 3 picks the zero-extended 26-bit jump target (0) or the bit-2 result (1).
- R10: When bit 11 is high, the stack pointer loads the ALU result; otherwise it holds. The memory address is the ALU result (bit 20 = 0) or the stack pointer (bit 20 = 1), and bit 21 = 1 overrides it with the program counter.
- R11: mem_wdata is read holding register 2 when bit 22 is 0 and read holding register 1 when bit 22 is 1.
- R12: When bit 5 is high, both read holding registers capture the register file at the edge. A write in the same cycle is not seen until a later read. When bit 5 is low, both holding registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 29 | Flat control word from the control unit |
| mem_rdata | input | 32 | Word returned by memory |
| instr | output | 32 | Current instruction register |
| zero | output | 1 | ALU result equals zero |
| mem_addr | output | 32 | Word address to memory |
| mem_wdata | output | 32 | Data offered to memory for a store or push |

## Verification
On every cycle the assertions check the load-or-hold behaviour of the instruction register, program counter, stack pointer and read holding registers. They also check that a stack-pointer load takes the ALU result of the previous cycle. Only the bench scenarios can show that each multiplexer step routes the right source. The same holds for the push, pop, branch, jump, link and upper-immediate flows producing the right addresses and stored values, and for the ALU codes and the zero flag matching an independent model under random control words.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int CTRL_W = 29;
    // control word bit positions (shared with the external sequencer)
    localparam int CB_PC_LOAD  = 0;
    localparam int CB_PC_S1    = 1;
    localparam int CB_PC_S2    = 2;
    localparam int CB_PC_S3    = 3;
    localparam int CB_IR_LOAD  = 4;
    localparam int CB_RF_READ  = 5;
    localparam int CB_RF_WRITE = 6;
    localparam int CB_RA_ZERO  = 7;
    localparam int CB_WA_S1    = 8;
    localparam int CB_WA_S2    = 9;
    localparam int CB_WA_S3    = 10;
    localparam int CB_SP_LOAD  = 11;
    localparam int CB_OPA_SEL  = 12;
    localparam int CB_OPB_S1   = 13;
    localparam int CB_OPB_S2   = 14;
    localparam int CB_OPB_S3   = 15;
    localparam int CB_OPB_S4   = 16;
    localparam int CB_WD_S1    = 17;
    localparam int CB_WD_S2    = 18;
    localparam int CB_WD_S3    = 19;
    localparam int CB_MA_S1    = 20;
    localparam int CB_MA_S2    = 21;
    localparam int CB_MD_SEL   = 22;
    localparam int CB_ALU_LO   = 23;
    localparam int CB_ALU_HI   = 28;

    typedef enum logic [5:0] {
        ALU_NONE = 6'd0,
        ALU_ADD  = 6'd1,
        ALU_SUB  = 6'd2,
        ALU_MUL  = 6'd3,
        ALU_SRL  = 6'd4,
        ALU_SLL  = 6'd5,
        ALU_AND  = 6'd6,
        ALU_OR   = 6'd7,
        ALU_NOR  = 6'd8,
        ALU_SLT  = 6'd9
    } alu_op_e;
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_d;
        always_comb begin
            word_d = word_q[g];
            if (we && (waddr == AW'(g))) begin
                word_d = wdata;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    assign rdata_a = word_q[raddr_a];
    assign rdata_b = word_q[raddr_b];
endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW   = 32,
    localparam int SHW = $clog2(DW)
) (
    input  logic [5:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] result,
    output logic          zero
);
    always_comb begin
        case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_MUL: result = opnd_a * opnd_b;
            ALU_SRL: result = opnd_a >> opnd_b[SHW-1:0];
            ALU_SLL: result = opnd_a << opnd_b[SHW-1:0];
            ALU_AND: result = opnd_a & opnd_b;
            ALU_OR:  result = opnd_a | opnd_b;
            ALU_NOR: result = ~(opnd_a | opnd_b);
            ALU_SLT: result = ($signed(opnd_a) < $signed(opnd_b)) ? DW'(1) : '0;
            default: result = '0;
        endcase
    end

    assign zero = (result == '0);
endmodule

// File: rtl/stk_opnd.sv
module stk_opnd #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] hold_a,
    input  logic [DW-1:0] hold_b,
    input  logic [DW-1:0] sp,
    input  logic [4:0]    shamt,
    input  logic [15:0]   imm,
    input  logic          sel_a,
    input  logic [3:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    logic [DW-1:0] step1, step2, step3;

    always_comb begin
        opnd_a = sel_a ? sp : hold_a;
        step1  = sel_b[0] ? DW'(shamt) : DW'(1);
        step2  = sel_b[1] ? {{(DW-16){imm[15]}}, imm} : DW'(imm);
        step3  = sel_b[2] ? step1 : step2;
        opnd_b = sel_b[3] ? hold_b : step3;
    end
endmodule

// File: rtl/stk_wb_sel.sv
module stk_wb_sel #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [4:0]    rt,
    input  logic [4:0]    rd,
    input  logic [15:0]   imm,
    input  logic [DW-1:0] alu_res,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] pc_inc,
    input  logic [2:0]    sel_wa,
    input  logic [2:0]    sel_wd,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    logic [AW-1:0] wa1, wa2;
    logic [DW-1:0] wd1, wd2;

    always_comb begin
        wa1   = sel_wa[0] ? AW'(rt) : AW'(rd);
        wa2   = sel_wa[1] ? AW'(DEPTH - 1) : '0;
        waddr = sel_wa[2] ? wa1 : wa2;
        wd1   = sel_wd[0] ? mem_rdata : alu_res;
        wd2   = sel_wd[1] ? {imm, {(DW-16){1'b0}}} : wd1;
        wdata = sel_wd[2] ? wd2 : pc_inc;
    end
endmodule

// File: rtl/stack_dpath.sv
module stack_dpath
    import stk_pkg::*;
#(
    parameter int DW            = 32,
    parameter int RF_DEPTH      = 32,
    parameter logic [31:0] PC_INIT = 32'h0000_1000,
    parameter logic [31:0] SP_INIT = 32'h03FF_FFFF,
    localparam int AW           = $clog2(RF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     instr,
    output logic              zero,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] sp;
        logic [DW-1:0] ir;
        logic [DW-1:0] hold_a;
        logic [DW-1:0] hold_b;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic [4:0]    f_rs, f_rt, f_rd, f_shamt;
    logic [15:0]   f_imm;
    logic [25:0]   f_jump;
    logic [AW-1:0] ra_a, ra_b, rf_waddr;
    logic [DW-1:0] rf_a, rf_b, rf_wdata;
    logic [DW-1:0] opnd_a, opnd_b, alu_res;
    logic [DW-1:0] pc_inc, npc1, npc2, npc3;

    assign f_rs    = st_q.ir[25:21];
    assign f_rt    = st_q.ir[20:16];
    assign f_rd    = st_q.ir[15:11];
    assign f_shamt = st_q.ir[10:6];
    assign f_imm   = st_q.ir[15:0];
    assign f_jump  = st_q.ir[25:0];

    assign ra_a = ctrl[CB_RA_ZERO] ? '0 : AW'(f_rs);
    assign ra_b = AW'(f_rt);

    stk_regfile #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl[CB_RF_WRITE]),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ra_a),
        .raddr_b (ra_b),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    stk_opnd #(.DW(DW)) u_opnd (
        .hold_a (st_q.hold_a),
        .hold_b (st_q.hold_b),
        .sp     (st_q.sp),
        .shamt  (f_shamt),
        .imm    (f_imm),
        .sel_a  (ctrl[CB_OPA_SEL]),
        .sel_b  (ctrl[CB_OPB_S4:CB_OPB_S1]),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b)
    );

    stk_alu #(.DW(DW)) u_alu (
        .op     (ctrl[CB_ALU_HI:CB_ALU_LO]),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (alu_res),
        .zero   (zero)
    );

    stk_wb_sel #(.DW(DW), .DEPTH(RF_DEPTH)) u_wb (
        .rt        (f_rt),
        .rd        (f_rd),
        .imm       (f_imm),
        .alu_res   (alu_res),
        .mem_rdata (mem_rdata),
        .pc_inc    (pc_inc),
        .sel_wa    (ctrl[CB_WA_S3:CB_WA_S1]),
        .sel_wd    (ctrl[CB_WD_S3:CB_WD_S1]),
        .waddr     (rf_waddr),
        .wdata     (rf_wdata)
    );

    always_comb begin
        pc_inc = st_q.pc + DW'(1);
        npc1   = ctrl[CB_PC_S1] ? pc_inc : st_q.hold_a;
        npc2   = ctrl[CB_PC_S2] ? (pc_inc + {{(DW-16){f_imm[15]}}, f_imm}) : npc1;
        npc3   = ctrl[CB_PC_S3] ? npc2 : DW'(f_jump);

        st_d = st_q;
        if (ctrl[CB_PC_LOAD]) st_d.pc = npc3;
        if (ctrl[CB_IR_LOAD]) st_d.ir = mem_rdata;
        if (ctrl[CB_SP_LOAD]) st_d.sp = alu_res;
        if (ctrl[CB_RF_READ]) begin
            st_d.hold_a = rf_a;
            st_d.hold_b = rf_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc     <= DW'(PC_INIT);
            st_q.sp     <= DW'(SP_INIT);
            st_q.ir     <= '0;
            st_q.hold_a <= '0;
            st_q.hold_b <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr     = st_q.ir;
    assign mem_addr  = ctrl[CB_MA_S2] ? st_q.pc : (ctrl[CB_MA_S1] ? st_q.sp : alu_res);
    assign mem_wdata = ctrl[CB_MD_SEL] ? st_q.hold_a : st_q.hold_b;
endmodule

// File: rtl/stack_dpath_chk.sv
module stack_dpath_chk
    import stk_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DW-1:0]     mem_rdata,
    input logic [DW-1:0]     instr,
    input logic [DW-1:0]     pc,
    input logic [DW-1:0]     sp,
    input logic [DW-1:0]     hold_a,
    input logic [DW-1:0]     hold_b,
    input logic [DW-1:0]     alu_res
);
    // R2
    ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CB_IR_LOAD] |=> instr == $past(mem_rdata));
    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_IR_LOAD] |=> $stable(instr));
    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_PC_LOAD] |=> $stable(pc));
    // R10
    sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CB_SP_LOAD] |=> sp == $past(alu_res));
    // R10
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_SP_LOAD] |=> $stable(sp));
    // R12
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_RF_READ] |=> ($stable(hold_a) && $stable(hold_b)));
endmodule

bind stack_dpath stack_dpath_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .instr     (instr),
    .pc        (st_q.pc),
    .sp        (st_q.sp),
    .hold_a    (st_q.hold_a),
    .hold_b    (st_q.hold_b),
    .alu_res   (alu_res)
);

// File: tb/stack_dpath_bench.sv
module stack_dpath_bench;
    import stk_pkg::*;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] ctrl = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] instr, mem_addr, mem_wdata;
    logic        zero;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_rf [32];
    logic [31:0] m_pc, m_sp, m_ir, m_h1, m_h2;

    always #(CLK_P/2) clk = ~clk;

    stack_dpath u_stack_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .instr     (instr),
        .zero      (zero),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    function automatic logic [31:0] ref_alu(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            6'd1: return a + b;
            6'd2: return a - b;
            6'd3: return a * b;
            6'd4: return a >> b[4:0];
            6'd5: return a << b[4:0];
            6'd6: return a & b;
            6'd7: return a | b;
            6'd8: return ~(a | b);
            6'd9: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive one cycle, compare outputs with the model, advance the model
    task automatic step(input logic [28:0] c, input logic [31:0] rd, input string tag);
        logic [31:0] sx, a, b, s1, s2, s3, alu, pcp1, np, wd, ma;
        logic [4:0]  wa;
        @(negedge clk);
        ctrl = c;
        mem_rdata = rd;
        #1;
        sx   = {{16{m_ir[15]}}, m_ir[15:0]};
        a    = c[12] ? m_sp : m_h1;
        s1   = c[13] ? {27'd0, m_ir[10:6]} : 32'd1;
        s2   = c[14] ? sx : {16'd0, m_ir[15:0]};
        s3   = c[15] ? s1 : s2;
        b    = c[16] ? m_h2 : s3;
        alu  = ref_alu(c[28:23], a, b);
        ma   = c[21] ? m_pc : (c[20] ? m_sp : alu);
        chk(instr, m_ir, {tag, " instr"});
        chk({31'd0, zero}, {31'd0, alu == 32'd0}, {tag, " zero"});
        chk(mem_addr, ma, {tag, " mem_addr"});
        chk(mem_wdata, c[22] ? m_h1 : m_h2, {tag, " mem_wdata"});
        pcp1 = m_pc + 32'd1;
        np   = c[1] ? pcp1 : m_h1;
        np   = c[2] ? pcp1 + sx : np;
        np   = c[3] ? np : {6'd0, m_ir[25:0]};
        wa   = c[10] ? (c[8] ? m_ir[20:16] : m_ir[15:11]) : (c[9] ? 5'd31 : 5'd0);
        wd   = c[17] ? rd : alu;
        wd   = c[18] ? {m_ir[15:0], 16'd0} : wd;
        wd   = c[19] ? wd : pcp1;
        @(posedge clk);
        if (c[5]) begin
            m_h1 = m_rf[c[7] ? 5'd0 : m_ir[25:21]];
            m_h2 = m_rf[m_ir[20:16]];
        end
        if (c[6]) m_rf[wa] = wd;
        if (c[0]) m_pc = np;
        if (c[4]) m_ir = rd;
        if (c[11]) m_sp = alu;
    endtask

    // set a control word with no load bits and let outputs settle
    task automatic look(input logic [28:0] c);
        @(negedge clk);
        ctrl = c;
        #1;
    endtask

    task automatic load_ir(input logic [31:0] w);
        logic [28:0] c = '0;
        c[CB_IR_LOAD] = 1'b1;
        step(c, w, "R2 ir load");
    endtask

    initial begin
        #(CLK_P * 50000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [28:0] c;
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = 32'h1000; m_sp = 32'h03FF_FFFF; m_ir = '0; m_h1 = '0; m_h2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        c = '0; c[CB_MA_S2] = 1'b1; look(c);
        chk(mem_addr, 32'h0000_1000, "R1 pc reset");
        chk(instr, 32'h0, "R1 ir reset");
        chk(mem_wdata, 32'h0, "R1 holding reset");
        c = '0; c[CB_MA_S1] = 1'b1; look(c);
        chk(mem_addr, 32'h03FF_FFFF, "R1 sp reset");

        // R7 R8 write r0 from memory data through rt
        load_ir({6'h08, 5'd0, 5'd0, 16'h0});
        c = '0; c[CB_RF_WRITE] = 1; c[CB_WA_S1] = 1; c[CB_WA_S3] = 1; c[CB_WD_S1] = 1; c[CB_WD_S3] = 1;
        step(c, 32'h55, "R7 R8 write r0");

        // R6 R11 R10 push: read port 1 forced to r0, SP as operand A, constant 1 as operand B
        c = '0; c[CB_RF_READ] = 1; c[CB_RA_ZERO] = 1;
        step(c, 32'h0, "R6 R12 read r0");
        c = '0; c[CB_OPA_SEL] = 1; c[CB_OPB_S3] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_SUB;
        c[CB_MA_S1] = 1; c[CB_MD_SEL] = 1;
        look(c);
        chk(mem_addr, 32'h03FF_FFFF, "R10 push address");
        chk(mem_wdata, 32'h55, "R11 push data");
        c[CB_SP_LOAD] = 1;
        step(c, 32'h0, "R5 R10 push");
        c = '0; c[CB_MA_S1] = 1; look(c);
        chk(mem_addr, 32'h03FF_FFFE, "R10 sp decremented");
        c = '0; c[CB_OPA_SEL] = 1; c[CB_OPB_S3] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_ADD;
        look(c);
        chk(mem_addr, 32'h03FF_FFFF, "R10 pop address");

        // R9 branch backwards by 2 and absolute jump
        load_ir({6'h05, 5'd0, 5'd0, 16'hFFFE});
        c = '0; c[CB_PC_LOAD] = 1; c[CB_PC_S1] = 1; c[CB_PC_S2] = 1; c[CB_PC_S3] = 1;
        step(c, 32'h0, "R9 branch");
        c = '0; c[CB_MA_S2] = 1; look(c);
        chk(mem_addr, 32'h0000_0FFF, "R9 branch target");
        load_ir({6'h02, 26'h000_2345});
        c = '0; c[CB_PC_LOAD] = 1;
        step(c, 32'h0, "R9 jump");
        c = '0; c[CB_MA_S2] = 1; look(c);
        chk(mem_addr, 32'h0000_2345, "R9 jump target");

        // R8 upper immediate into r7 via rt
        load_ir({6'h0f, 5'd0, 5'd7, 16'hABCD});
        c = '0; c[CB_RF_WRITE] = 1; c[CB_WA_S1] = 1; c[CB_WA_S3] = 1; c[CB_WD_S2] = 1; c[CB_WD_S3] = 1;
        step(c, 32'h0, "R8 lui write");
        // R7 R8 link PC+1 into r31
        c = '0; c[CB_RF_WRITE] = 1; c[CB_WA_S2] = 1;
        step(c, 32'h0, "R7 link write");
        load_ir({6'h00, 5'd31, 5'd7, 5'd0, 5'd0, 6'h20});
        c = '0; c[CB_RF_READ] = 1;
        step(c, 32'h0, "R12 read r31 r7");
        c = '0; look(c);
        chk(mem_wdata, 32'hABCD_0000, "R8 lui value");
        c = '0; c[CB_MD_SEL] = 1; look(c);
        chk(mem_wdata, 32'h0000_2346, "R7 R8 link value");

        // R3 signed compare, R4 zero flag
        c = '0; c[CB_OPB_S4] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_SLT; look(c);
        chk(mem_addr, 32'h0, "R3 slt r31<r7 false");
        load_ir({6'h00, 5'd7, 5'd0, 5'd0, 5'd0, 6'h2a});
        c = '0; c[CB_RF_READ] = 1;
        step(c, 32'h0, "R12 read r7 r0");
        c = '0; c[CB_OPB_S4] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_SLT; look(c);
        chk(mem_addr, 32'h1, "R3 slt negative");
        c = '0; c[CB_OPB_S4] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_SUB; look(c);
        chk({31'd0, zero}, 32'h0, "R4 zero low");
        load_ir({6'h04, 5'd7, 5'd7, 16'h0});
        c = '0; c[CB_RF_READ] = 1;
        step(c, 32'h0, "R12 read r7 twice");
        c = '0; c[CB_OPB_S4] = 1; c[CB_ALU_HI:CB_ALU_LO] = ALU_SUB; look(c);
        chk({31'd0, zero}, 32'h1, "R4 zero high");

        // random control words against the model
        for (int n = 0; n < 600; n++) begin
            c = 29'($urandom);
            c[CB_ALU_HI:CB_ALU_LO] = 6'($urandom_range(0, 11));
            step(c, $urandom, "R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule